// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block turns four asynchronous external interrupt pins into interrupt requests for a downstream interrupt controller. Each pin first passes through a two-flop synchronizer. Two per-channel settings then decide when the pin counts as asserted. One setting picks level or edge sensing. The other picks the active polarity: high or rising, versus low or falling.

Each channel has a sticky flag, and the flag drives that channel's request output. Software configures the block and services it through a small register port. The port has a sensing-select register, a polarity register and the flag register, and all three can be read back. A flag is cleared by writing a one to its bit. A configuration change can make a channel look as if it had just become active, and so can raise a false flag. Software is expected to clear the flags after it reconfigures the block.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, the mode, polarity and flag registers read zero and all request outputs are low. The synchronizer stages reset to one, so a high pin raises nothing under the default low-level setting.
- R2: Register address 1 holds the mode bits (bit n is channel n: 0 = level, 1 = edge). Address 2 holds the polarity bits (1 = high or rising, 0 = low or falling). Address 0 reads the flags. Each register holds its value until it is written, and a read returns the last value written.
- R3: In level mode with polarity 0, a channel's flag sets while its pin is low. It stays clear while the pin is high.
- R4: In level mode with polarity 1, a channel's flag sets while its pin is high.
- R5: In edge mode with polarity 1, a rising pin transition sets the flag.
- R6: In edge mode with polarity 0, a falling pin transition sets the flag.
- R7: A set flag stays set after the pin returns to its inactive state, until software clears it.
- R8: Writing address 0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R9: In level mode, a clear written while the pin is still active leaves the flag set in the following cycle.
- R10: A polarity change that makes a steady pin look newly active raises a spurious edge flag, which a clear write then removes.
- R11: A pin change first shows on the request output after the third rising clock edge following the change.
- R12: The channels are independent: activity on one pin never sets another channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | CH | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | CH | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | CH | Read data, combinational from rd_addr |
| irq_o | output | CH | Per-channel interrupt request (the flag) |

## Verification
A pin change is due on irq_o after the third rising edge following the change: two edges go to the synchronizer and one to the flag register. The directed checks therefore sample at the falling edge after the second rising edge, where the output must not yet have moved, and again after the third, where it must have. A flag-clear write or a configuration write takes effect at the next rising edge, so each of those checks samples at the falling edge that immediately follows. In the random phase, a cycle model updated on the same rising edges is compared with irq_o at every falling edge.

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int CH = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] pin_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CH-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CH-1:0] rd_data,
  output logic [CH-1:0] irq_o
);
  localparam logic [AW-1:0] ADDR_FLAG = AW'(0);
  localparam logic [AW-1:0] ADDR_MODE = AW'(1);
  localparam logic [AW-1:0] ADDR_POL  = AW'(2);

  logic [CH-1:0] meta_q, sync_q;
  logic [CH-1:0] mode_q, pol_q, flag_q, act_q;
  logic [CH-1:0] act, set, clr;

  assign act = ~(sync_q ^ pol_q);
  assign set = (mode_q & act & ~act_q) | (~mode_q & act);
  assign clr = (wr_en && wr_addr == ADDR_FLAG) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      act_q  <= '0;
      flag_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      act_q  <= act;
      flag_q <= (flag_q & ~clr) | set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_MODE) mode_q <= wr_data;
      if (wr_addr == ADDR_POL)  pol_q  <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_FLAG: rd_data = flag_q;
      ADDR_MODE: rd_data = mode_q;
      ADDR_POL:  rd_data = pol_q;
      default:   rd_data = '0;
    endcase
  end

  assign irq_o = flag_q;
endmodule

module ext_irq_cond_chk #(
  parameter int CH = 4,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [CH-1:0] wr_data,
  input logic [CH-1:0] mode_q,
  input logic [CH-1:0] pol_q,
  input logic [CH-1:0] flag_q,
  input logic [CH-1:0] act
);
  logic [CH-1:0] wipe;
  assign wipe = (wr_en && wr_addr == AW'(0)) ? wr_data : '0;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> flag_q == '0);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == AW'(1)) |=> $stable(mode_q));
  // R2
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == AW'(2)) |=> $stable(pol_q));
  // R7
  edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(mode_q & flag_q & ~wipe) & ~flag_q) == '0);
  // R3
  level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(~mode_q & ~act & ~flag_q) & flag_q) == '0);
  // R9
  level_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(~mode_q & act) & ~flag_q) == '0);
  // R8
  wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(mode_q & wipe) & flag_q & ~$past(act)) == '0);
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.CH(CH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mode_q(mode_q), .pol_q(pol_q), .flag_q(flag_q),
  .act(act)
);

// File: tb/sim_ext_irq_cond.sv
module sim_ext_irq_cond;
  logic clk = 0, rst_n = 0;
  logic [3:0] pin = 4'hF, wd = 0, rd, irq;
  logic we = 0;
  logic [1:0] wa = 0, ra = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_cond u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin), .wr_en(we),
    .wr_addr(wa), .wr_data(wd), .rd_addr(ra), .rd_data(rd), .irq_o(irq));

  logic [3:0] m1 = 4'hF, m2 = 4'hF, mmode = 0, mpol = 0, mflag = 0, mprev = 0;

  function automatic logic [3:0] asserted(logic [3:0] s, logic [3:0] p);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = p[i] ? s[i] : !s[i];
    return r;
  endfunction

  function automatic logic [3:0] next_flag(logic [3:0] f, logic [3:0] md,
      logic [3:0] a, logic [3:0] pa, logic [3:0] c);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      r[i] = c[i] ? 1'b0 : f[i];
      if (md[i] ? (a[i] && !pa[i]) : a[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  always @(posedge clk) if (rst_n) begin
    logic [3:0] a;
    a = asserted(m2, mpol);
    mflag <= next_flag(mflag, mmode, a, mprev, (we && wa == 0) ? wd : 4'h0);
    mprev <= a;
    m1 <= pin;
    m2 <= m1;
    if (we && wa == 1) mmode <= wd;
    if (we && wa == 2) mpol <= wd;
  end

  task automatic check(bit ok, string tag, logic [3:0] actv, logic [3:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    @(negedge clk); we = 1; wa = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd77));
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    check(irq == 0, "R1 irq", irq, 0);
    for (int a = 0; a < 3; a++) begin
      ra = 2'(a); #1;
      check(rd == 0, "R1 regs", rd, 0);
    end
    cyc(4);
    check(irq == 0, "R3 high pin idle", irq, 0);
    // R2 readback
    wr(1, 4'hA); wr(2, 4'h5);
    ra = 1; #1; check(rd == 4'hA, "R2 mode", rd, 4'hA);
    ra = 2; #1; check(rd == 4'h5, "R2 pol", rd, 4'h5);

    for (int ch = 0; ch < 4; ch++)
      for (int cmb = 0; cmb < 4; cmb++) begin
        logic m, p;
        logic [3:0] bit_ch;
        m = cmb[1]; p = cmb[0];
        bit_ch = 4'(1 << ch);
        pin = p ? 4'h0 : 4'hF;
        wr(1, {4{m}}); wr(2, {4{p}});
        cyc(4);
        wr(0, 4'hF);
        check(irq == 0, "R8 cleared before test", irq, 0);
        @(negedge clk); pin[ch] = p;
        cyc(2);
        check(irq == 0, "R11 not yet", irq, 0);
        cyc(1);
        check(irq == bit_ch, m ? (p ? "R5 rising" : "R6 falling")
                               : (p ? "R4 level high" : "R3 level low"), irq, bit_ch);
        if (!m) begin
          wr(0, bit_ch);
          check(irq == bit_ch, "R9 level reasserts", irq, bit_ch);
        end
        pin[ch] = !p;
        cyc(4);
        check(irq == bit_ch, "R7 held and R12 others clear", irq, bit_ch);
        wr(0, ~bit_ch);
        check(irq == bit_ch, "R8 zero bit no effect", irq, bit_ch);
        ra = 0; #1; check(rd == bit_ch, "R2 flag read", rd, bit_ch);
        wr(0, bit_ch);
        check(irq == 0, "R8 clear", irq, 0);
      end

    // R10 spurious flag from polarity change
    pin = 4'hF;
    wr(1, 4'hF); wr(2, 4'h0);
    cyc(4);
    wr(0, 4'hF);
    wr(2, 4'hF);
    cyc(1);
    check(irq == 4'hF, "R10 spurious", irq, 4'hF);
    wr(0, 4'hF);
    cyc(2);
    check(irq == 0, "R10 cleared", irq, 0);

    // random phase against model (R11, R12)
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      check(irq == mflag, "R11 R12 random", irq, mflag);
      we = 0;
      if ($urandom_range(0, 3) == 0) pin = pin ^ 4'(1 << $urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) begin
        we = 1; wa = 2'($urandom_range(0, 2)); wd = 4'($urandom);
      end
    end
    @(negedge clk); we = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule